// File: doc/BRIEF.md
# Signal Trace Capture Unit

This block is an on-chip logic analyser. It watches a packed probe vector and records a frame each time the vector changes. Each frame holds the probe value and the number of recording cycles that went by since the previous frame. Frames go into an internal buffer. Recording begins a programmable number of cycles after a start command. It ends when a programmable stop delay runs out or when the buffer is full.

A host drives the unit through one 64-bit write port and one 64-bit read port. Every write carries a 3-bit code and an argument. Some codes start or stop a capture. The others choose what the read port shows: completion status, probe width, frame count, start offset or the frame stream.

The frame stream is the only flowing interface. The read data stays steady until the host pulses the read strobe, which consumes the word. So the host applies back-pressure simply by not strobing, and it may pause for any length of time.

Top module: `trace_capture_unit`

## Requirements
- R1: A write holds its code in bits [2:0] and its argument in bits [63:3]. Code 4 starts a capture and code 5 arms the stop delay; neither changes the read selection. Codes 0, 1, 2, 3 and 6 each select a read view, and code 7 selects a view that reads 0.
- R2: Code 4 with argument D clears the buffer. The first recording clock edge is the D+2th edge after the write edge. Selection code 6 then reads D.
- R3: On its first recording edge a capture always stores a frame. On later recording edges it stores one whenever the probe differs from the last stored value.
- R4: A frame's delta is the count of recording edges with no store since the previous store. The first frame lands offset+delta+2 edges after the start write, and each later frame lands delta+1 edges after the one before.
- R5: When the delta counter holds its all-ones value (2^DELTA_W-1), a frame is stored even though the probe has not changed, and the counter then restarts at 0.
- R6: Code 5 with argument S makes the S+1th edge after the write the last edge on which recording may occur. If that edge falls during the start delay, the capture ends with no frames.
- R7: Recording stops once DEPTH frames are held.
- R8: Selection code 0 reads 1 once recording has ended and at least one stored frame is still unread, including while the last frame's words are being fetched. At all other times it reads 0, including after reset.
- R9: Selection code 2 reads PROBE_W and selection code 3 reads the number of stored frames.
- R10: Under selection code 1, each strobed read moves through the stream, oldest frame first. A frame is its delta word followed by ceil(PROBE_W/64) data words. Probe bit 0 sits at bit 0 of the first data word, and the last word is zero-padded. Reselecting code 1 resumes where the stream left off, and with no strobe the word holds.
- R11: Stream reads before recording ends, or after every frame has been consumed, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | PROBE_W | Probe vector under observation |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 64 | Code in [2:0], argument in [63:3] |
| host_rd_i | input | 1 | Read strobe; consumes a stream word |
| host_rdata_o | output | 64 | Data of the selected view |

## Verification
A corrupted delta counter or an off-by-one start delay shows up at the ports only after readout. It appears as a delta word whose value breaks the offset+delta+2 or delta+1 timing relation against the real store cycles. A stuck read pointer or word index shows up within a single strobe as a repeated or skipped stream word. A wrong frame count or early termination shows up as a count readback mismatch, or as the status view dropping to 0 before the last frame's final word.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [2:0] {
    SEL_VALID  = 3'd0,
    SEL_DATA   = 3'd1,
    SEL_WIDTH  = 3'd2,
    SEL_COUNT  = 3'd3,
    CMD_START  = 3'd4,
    CMD_STOP   = 3'd5,
    SEL_OFFSET = 3'd6,
    SEL_NONE   = 3'd7
  } host_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_REC,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] arg_i,
  input  logic             full_i,
  output logic             rec_o,
  output logic             done_o,
  output logic [CNT_W-1:0] offset_o
);
  cap_state_e       state_q;
  logic [CNT_W-1:0] dly_q, stp_q;
  logic             stp_arm_q;
  logic             stp_exp;

  assign stp_exp = stp_arm_q && (stp_q == '0) && !stop_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stp_arm_q <= 1'b0;
      stp_q     <= '0;
    end else if (stop_i) begin
      stp_arm_q <= 1'b1;
      stp_q     <= arg_i;
    end else if (stp_arm_q) begin
      if (stp_q == '0) stp_arm_q <= 1'b0;
      else             stp_q     <= stp_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dly_q    <= '0;
      offset_o <= '0;
    end else if (start_i) begin
      state_q  <= ST_DELAY;
      dly_q    <= arg_i;
      offset_o <= arg_i;
    end else begin
      case (state_q)
        ST_DELAY: begin
          if (stp_exp)              state_q <= ST_DONE;
          else if (dly_q == '0)     state_q <= ST_REC;
          else                      dly_q   <= dly_q - 1'b1;
        end
        ST_REC: if (stp_exp || full_i) state_q <= ST_DONE;
        default: ;
      endcase
    end
  end

  assign rec_o  = (state_q == ST_REC);
  assign done_o = (state_q == ST_DONE);

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R6
  AST_REC_FROM_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_o ##1 rec_o) |-> ($past(state_q) == ST_DELAY)); // R2
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int PROBE_W = 72,
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               rec_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [$clog2(DEPTH+1)-1:0] rd_addr_i,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic               full_o,
  output logic [DELTA_W-1:0] rd_delta_o,
  output logic [PROBE_W-1:0] rd_probe_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DELTA_W-1:0] DMAX = {DELTA_W{1'b1}};

  logic [PROBE_W-1:0] pmem [DEPTH];
  logic [DELTA_W-1:0] dmem [DEPTH];
  logic [PROBE_W-1:0] last_q;
  logic [DELTA_W-1:0] delta_q;
  logic               first_q;
  logic               take;
  logic [AW-1:0]      wr_idx, rd_idx;

  assign full_o = (count_o == CW'(DEPTH));
  assign take   = rec_i && !full_o &&
                  (first_q || (probe_i != last_q) || (delta_q == DMAX));
  assign wr_idx = count_o[AW-1:0];
  assign rd_idx = rd_addr_i[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
      delta_q <= '0;
      first_q <= 1'b1;
      last_q  <= '0;
    end else if (clr_i) begin
      count_o <= '0;
      delta_q <= '0;
      first_q <= 1'b1;
    end else if (take) begin
      count_o <= count_o + 1'b1;
      delta_q <= '0;
      first_q <= 1'b0;
      last_q  <= probe_i;
    end else if (rec_i && !full_o) begin
      delta_q <= delta_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !clr_i) begin
      pmem[wr_idx] <= probe_i;
      dmem[wr_idx] <= delta_q;
    end
  end

  assign rd_probe_o = (rd_addr_i < CW'(DEPTH)) ? pmem[rd_idx] : '0;
  assign rd_delta_o = (rd_addr_i < CW'(DEPTH)) ? dmem[rd_idx] : '0;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CW'(DEPTH)); // R7
  AST_CHANGE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && !full_o && !clr_i && !first_q && probe_i != last_q)
      |=> count_o == $past(count_o) + 1'b1); // R3
  AST_SAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && !full_o && !clr_i && delta_q == DMAX) |=> delta_q == '0); // R5
endmodule

// File: rtl/trace_readout.sv
module trace_readout
  import trace_pkg::*;
#(
  parameter int PROBE_W = 72,
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               sel_wr_i,
  input  logic [2:0]         sel_i,
  input  logic               rd_i,
  input  logic               done_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic [CNT_W-1:0]   offset_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic [PROBE_W-1:0] probe_i,
  output logic [$clog2(DEPTH+1)-1:0] rd_addr_o,
  output logic [63:0]        rdata_o
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int FW = (PROBE_W + 63) / 64;
  localparam int WW = $clog2(FW + 1);

  host_code_e          sel_q;
  logic [WW-1:0]       word_q;
  logic [CW-1:0]       frame_q;
  logic                avail;
  logic [FW*64-1:0]    padded;
  logic [63:0]         data_word;
  int                  wsel;

  assign avail     = done_i && (frame_q < count_i);
  assign rd_addr_o = frame_q;
  assign padded    = (FW*64)'(probe_i);
  assign wsel      = (word_q == '0) ? 0 : (int'(word_q) - 1);
  assign data_word = padded[wsel*64 +: 64];

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_VALID;
    else if (sel_wr_i) sel_q <= host_code_e'(sel_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      frame_q <= '0;
      word_q  <= '0;
    end else if (rd_i && sel_q == SEL_DATA && avail) begin
      if (word_q == WW'(FW)) begin
        word_q  <= '0;
        frame_q <= frame_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (sel_q)
      SEL_VALID:  rdata_o = {63'd0, avail};
      SEL_DATA:   rdata_o = !avail ? 64'd0 :
                            (word_q == '0) ? 64'(delta_i) : data_word;
      SEL_WIDTH:  rdata_o = 64'(PROBE_W);
      SEL_COUNT:  rdata_o = 64'(count_i);
      SEL_OFFSET: rdata_o = 64'(offset_i);
      default:    rdata_o = 64'd0;
    endcase
  end

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= count_i); // R11
  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    word_q <= WW'(FW)); // R10
  AST_NO_STROBE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_i && !clr_i) |=> ($stable(frame_q) && $stable(word_q))); // R10
endmodule

// File: rtl/trace_capture_unit.sv
module trace_capture_unit
  import trace_pkg::*;
#(
  parameter int PROBE_W = 72,
  parameter int DEPTH   = 16,
  parameter int DELTA_W = 8,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               host_wr_i,
  input  logic [63:0]        host_wdata_i,
  input  logic               host_rd_i,
  output logic [63:0]        host_rdata_o
);
  localparam int CW = $clog2(DEPTH+1);

  host_code_e         code;
  logic [CNT_W-1:0]   arg;
  logic               start, stop, sel_wr;
  logic               rec, done, full;
  logic [CNT_W-1:0]   offset;
  logic [CW-1:0]      count, rd_addr;
  logic [DELTA_W-1:0] rd_delta;
  logic [PROBE_W-1:0] rd_probe;
  logic               unused_hi;

  assign code      = host_code_e'(host_wdata_i[2:0]);
  assign arg       = host_wdata_i[3 +: CNT_W];
  assign unused_hi = ^host_wdata_i[63:3+CNT_W];
  assign start     = host_wr_i && (code == CMD_START);
  assign stop      = host_wr_i && (code == CMD_STOP);
  assign sel_wr    = host_wr_i && !start && !stop;

  trace_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .arg_i(arg),
    .full_i(full), .rec_o(rec), .done_o(done), .offset_o(offset)
  );

  trace_store #(.PROBE_W(PROBE_W), .DEPTH(DEPTH), .DELTA_W(DELTA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .rec_i(rec), .probe_i(probe_i),
    .rd_addr_i(rd_addr), .count_o(count), .full_o(full),
    .rd_delta_o(rd_delta), .rd_probe_o(rd_probe)
  );

  trace_readout #(.PROBE_W(PROBE_W), .DEPTH(DEPTH), .DELTA_W(DELTA_W), .CNT_W(CNT_W)) u_readout (
    .clk(clk), .rst_n(rst_n), .clr_i(start), .sel_wr_i(sel_wr),
    .sel_i(host_wdata_i[2:0]), .rd_i(host_rd_i), .done_i(done),
    .count_i(count), .offset_i(offset), .delta_i(rd_delta), .probe_i(rd_probe),
    .rd_addr_o(rd_addr), .rdata_o(host_rdata_o)
  );

  AST_FULL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rec && full && !start) |=> done); // R7
endmodule

// File: tb/trace_capture_unit_bench.sv
`timescale 1ns/1ps
module trace_capture_unit_bench;
  localparam int PROBE_W = 72;
  localparam int DEPTH   = 16;
  localparam int DELTA_W = 8;
  localparam int CNT_W   = 32;
  localparam int FW      = (PROBE_W + 63) / 64;
  localparam int DMAX    = (1 << DELTA_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [PROBE_W-1:0] probe = '0;
  logic               host_wr = 1'b0;
  logic [63:0]        host_wdata = '0;
  logic               host_rd = 1'b0;
  logic [63:0]        host_rdata;

  always #2.5 clk = ~clk;

  trace_capture_unit #(.PROBE_W(PROBE_W), .DEPTH(DEPTH), .DELTA_W(DELTA_W), .CNT_W(CNT_W))
    u_trace_capture_unit (
      .clk(clk), .rst_n(rst_n), .probe_i(probe), .host_wr_i(host_wr),
      .host_wdata_i(host_wdata), .host_rd_i(host_rd), .host_rdata_o(host_rdata));

  int checks = 0, failures = 0;
  bit finished = 0;

  // ---------------- reference model built from the requirements ----------------
  longint cyc = 0;
  int     m_state = 0;            // 0 idle, 1 delay, 2 rec, 3 done
  longint m_dcnt = 0, m_scnt = 0, m_off = 0, m_start_cyc = 0;
  bit     m_sarm = 0, m_first = 1;
  int     m_cnt = 0, m_delta = 0;
  logic [PROBE_W-1:0] m_last = '0;
  logic [PROBE_W-1:0] e_probe [DEPTH];
  int     e_delta [DEPTH];
  longint e_time [DEPTH];
  bit     st, sp, sexp;
  int     old_cnt, old_state;
  longint arg;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_sarm = 0; m_cnt = 0; m_delta = 0; m_first = 1; m_off = 0;
    end else begin
      st = host_wr && host_wdata[2:0] == 3'd4;
      sp = host_wr && host_wdata[2:0] == 3'd5;
      arg = longint'(host_wdata[3 +: CNT_W]);
      sexp = m_sarm && m_scnt == 0 && !sp;
      old_cnt = m_cnt; old_state = m_state;
      if (st) begin
        m_cnt = 0; m_delta = 0; m_first = 1;
      end else if (old_state == 2 && old_cnt < DEPTH) begin
        if (m_first || probe != m_last || m_delta == DMAX) begin
          e_probe[m_cnt] = probe; e_delta[m_cnt] = m_delta; e_time[m_cnt] = cyc;
          m_cnt++; m_delta = 0; m_last = probe; m_first = 0;
        end else m_delta++;
      end
      if (sp) begin m_sarm = 1; m_scnt = arg; end
      else if (m_sarm) begin if (m_scnt == 0) m_sarm = 0; else m_scnt--; end
      if (st) begin m_state = 1; m_dcnt = arg; m_off = arg; m_start_cyc = cyc; end
      else if (old_state == 1) begin
        if (sexp) m_state = 3; else if (m_dcnt == 0) m_state = 2; else m_dcnt--;
      end else if (old_state == 2) begin
        if (sexp || old_cnt == DEPTH) m_state = 3;
      end
    end
  end

  // ---------------- probe stimulus ----------------
  int pmode = 0;   // 0 hold, 1 sparse random, 2 change every cycle
  always @(negedge clk) begin
    if (pmode == 1 && ($urandom % 4) == 0) probe <= {$urandom, $urandom, $urandom};
    else if (pmode == 2) probe <= probe + 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input int code, input longint a);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = {a[60:0], code[2:0]};
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(output logic [63:0] v);
    v = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  function automatic logic [63:0] exp_word(input logic [PROBE_W-1:0] p, input int j);
    logic [FW*64-1:0] pad;
    pad = (FW*64)'(p);
    return pad[j*64 +: 64];
  endfunction

  longint rd_deltas [DEPTH];

  task automatic check_readout();
    logic [63:0] v;
    longint off;
    host_write(0, 0);
    chk(host_rdata == 64'(m_cnt > 0), "R8 status after end", host_rdata, m_cnt > 0);
    host_write(2, 0);
    chk(host_rdata == 64'(PROBE_W), "R9 width", host_rdata, PROBE_W);
    host_write(3, 0);
    chk(host_rdata == 64'(m_cnt), "R9 count", host_rdata, m_cnt);
    host_write(6, 0);
    off = longint'(host_rdata);
    chk(off == m_off, "R2 offset", off, m_off);
    host_write(1, 0);
    for (int f = 0; f < m_cnt; f++) begin
      host_read(v);
      rd_deltas[f] = longint'(v);
      chk(v == 64'(e_delta[f]), "R4 delta word", v, e_delta[f]);
      if (f == 0)
        chk(e_time[0] - m_start_cyc == off + longint'(v) + 2, "R4 first frame time",
            e_time[0] - m_start_cyc, off + longint'(v) + 2);
      else
        chk(e_time[f] - e_time[f-1] == longint'(v) + 1, "R4 frame gap",
            e_time[f] - e_time[f-1], longint'(v) + 1);
      for (int j = 0; j < FW; j++) begin
        if (f == m_cnt - 1 && j == FW - 1) begin
          host_write(0, 0);
          chk(host_rdata == 64'd1, "R8 status during last frame", host_rdata, 1);
          host_write(1, 0);
        end
        host_read(v);
        chk(v == exp_word(e_probe[f], j), "R10 data word", v, exp_word(e_probe[f], j));
      end
    end
    host_read(v);
    chk(v == 64'd0, "R11 read past end", v, 0);
    host_write(0, 0);
    chk(host_rdata == 64'd0, "R8 status after drain", host_rdata, 0);
  endtask

  task automatic run_capture(input longint d, input longint s, input int mode);
    int guard;
    pmode = mode;
    host_write(4, d);
    host_write(5, s);
    guard = 0;
    while (m_state != 3 && guard < 5000) begin @(negedge clk); guard++; end
    pmode = 0;
    chk(m_state == 3, "R6 capture ended", m_state, 3);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [63:0] v;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdata == 64'd0, "R8 reset status", host_rdata, 0);
    host_write(3, 0);
    chk(host_rdata == 64'd0, "R9 reset count", host_rdata, 0);
    host_write(7, 0);
    chk(host_rdata == 64'd0, "R1 code 7 reads zero", host_rdata, 0);
    host_write(1, 0);
    host_read(v);
    chk(v == 64'd0, "R11 stream before capture", v, 0);

    // R3 R4 random sparse captures
    for (int k = 0; k < 4; k++) begin
      run_capture($urandom % 6, 30 + ($urandom % 60), 1);
      check_readout();
    end

    // R5 saturation with a held probe
    probe = {$urandom, $urandom, $urandom};
    run_capture(2, 600, 0);
    chk(m_cnt >= 2, "R5 extra frames with held probe", m_cnt, 2);
    check_readout();
    chk(rd_deltas[1] == DMAX, "R5 saturated delta", rd_deltas[1], DMAX);

    // R7 buffer fills
    run_capture(1, 500, 2);
    host_write(3, 0);
    chk(host_rdata == 64'(DEPTH), "R7 full count", host_rdata, DEPTH);
    check_readout();

    // R6 stop expiring inside the start delay
    run_capture(50, 3, 2);
    host_write(3, 0);
    chk(host_rdata == 64'd0, "R6 stop during delay", host_rdata, 0);
    host_write(0, 0);
    chk(host_rdata == 64'd0, "R8 no frames no status", host_rdata, 0);

    // R1 selection unchanged by start/stop, R10 hold without strobe
    run_capture(0, 10, 2);
    host_write(1, 0);
    v = host_rdata;
    repeat (3) @(negedge clk);
    chk(host_rdata == v, "R10 word holds without strobe", host_rdata, v);
    host_write(5, 7);
    chk(host_rdata == v, "R1 stop code keeps view", host_rdata, v);
    check_readout();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule